// File: doc/BRIEF.md
# Quad-Rate Burst-of-Four SRAM Port

This block is a synthesizable device-side model of a synchronous static memory with a separate read data port and write data port that share one address bus. It runs on a beat-rate clock. An input phase flag, `k_phase`, is high on the beats that fall on the rising edge of the slow input clock and low on the beats that fall on its falling edge. Each slow-clock period therefore carries two data beats.

Every command moves a burst of four words. A read command takes its burst address on the rising-edge beat on which it is issued. A write command takes its burst address on the falling-edge beat that follows, so one bus serves both directions. Write data arrives late, starting one slow-clock period after the command. Read data leaves one slow-clock period after its command, together with a valid strobe and an output-enable flag that models the output drivers. Read and write bursts run independently and may overlap. A request that arrives while a burst of the same kind is still owed its slot is dropped.

Top module: `qb4_sram`

## Requirements
- R1: Each accepted command transfers exactly four words, at word addresses `{burst_addr, 2'b00}` through `{burst_addr, 2'b11}`, in ascending order, one word per beat.
- R2: A read is accepted only when `rd_n` is low on a beat with `k_phase` high, and its burst address is `addr` on that same beat. `rd_n` on a beat with `k_phase` low has no effect.
- R3: For a read accepted on beat b, `rvalid` is high on beats b+2 through b+5. Word i of the burst is on `rdata` during beat b+2+i. A beat means the interval after the corresponding rising clock edge.
- R4: A write is accepted only when `wr_n` is low on a beat with `k_phase` high. Its burst address is `addr` on the next beat, which has `k_phase` low. `wr_n` on a beat with `k_phase` low has no effect.
- R5: For a write accepted on beat b, word i is taken from `wdata` on beat b+2+i. `wdata` on any other beat leaves the array unchanged.
- R6: `bw_n[j]` low on a write beat stores bits 9j to 9j+8 of `wdata` into that lane. `bw_n[j]` high leaves that lane of the word unchanged. `bw_n` is active low, one bit per 9-bit lane.
- R7: A read request on the rising-edge beat right after an accepted read is ignored, and the same holds for writes. A request one rising-edge beat later is accepted, so its four beats follow the previous burst with no gap.
- R8: When no burst continues, `rvalid` and `oe` both go low on the beat after the last word. `oe` is high exactly on beats that present read data.
- R9: Read and write bursts proceed independently. A read returns the array contents as they stood before any write committing on the same beat. There is no forwarding, so a read and a write to the same burst issued on the same rising-edge beat return all four old words.
- R10: While `rst` is high, `rvalid` and `oe` are low. Commands seen before `rst` is released are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| k_phase | input | 1 | High on rising-edge beats of the slow clock |
| rd_n | input | 1 | Active-low read request |
| wr_n | input | 1 | Active-low write request |
| addr | input | ADDR_W | Shared burst address bus |
| wdata | input | DATA_W | Write data beat |
| bw_n | input | DATA_W/9 | Active-low lane write enables |
| rdata | output | DATA_W | Read data beat |
| rvalid | output | 1 | Read beat valid / echo strobe |
| oe | output | 1 | Output drivers enabled |

## Verification
The bench builds the block with `ADDR_W = 3` and `DATA_W = 18`, which gives eight bursts, 32 words and two byte lanes. At that size every burst can be filled and read back in seamless streams, and every combination of the two lane enables occurs on every word offset. Dropped mid-burst requests, same-beat read/write collisions and randomly mixed traffic are all checked against a beat-indexed reference schedule derived from the timing rules. Requests on falling-edge beats are exercised as well.

// File: rtl/qb4_pkg.sv
package qb4_pkg;

    localparam int LANE_W  = 9;
    localparam int BURST_N = 4;
    localparam int IDX_W   = $clog2(BURST_N);

    // running burst: active flag and next word offset
    typedef struct packed {
        logic             act;
        logic [IDX_W-1:0] idx;
    } run_t;

    // write command slot progression
    typedef enum logic [1:0] {
        WC_IDLE     = 2'd0,
        WC_GET_ADDR = 2'd1,
        WC_ARMED    = 2'd2
    } wcmd_e;

    function automatic int lanes_of(input int width);
        return (width + LANE_W - 1) / LANE_W;
    endfunction

    // advance a running burst by one beat
    function automatic run_t run_step(input run_t r);
        run_t n;
        n.idx = r.idx + 1'b1;
        n.act = r.act && (r.idx != IDX_W'(BURST_N - 1));
        return n;
    endfunction

    // burst start after launch: word 0 emitted, next offset 1
    function automatic run_t run_launch();
        run_t n;
        n.act = 1'b1;
        n.idx = IDX_W'(1);
        return n;
    endfunction

endpackage

// File: rtl/qb4_rd_ctrl.sv
module qb4_rd_ctrl
    import qb4_pkg::*;
#(
    parameter  int ADDR_W = 4,
    localparam int WA_W   = ADDR_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              k_phase,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd_take,
    output logic              rd_fire,
    output logic [WA_W-1:0]   rd_word_addr,
    output logic              rvalid,
    output logic              oe
);

    logic              cmd_v;
    logic [ADDR_W-1:0] cmd_a;
    logic [ADDR_W-1:0] base;
    run_t              run;
    logic              launch;

    // a pending command occupies the next rising-edge slot
    assign rd_take = k_phase && !rd_n && !cmd_v;
    assign launch  = k_phase && cmd_v;
    assign rd_fire = launch || run.act;

    always_comb begin
        if (launch) rd_word_addr = {cmd_a, {IDX_W{1'b0}}};
        else        rd_word_addr = {base, run.idx};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_v  <= 1'b0;
            cmd_a  <= '0;
            base   <= '0;
            run    <= '0;
            rvalid <= 1'b0;
            oe     <= 1'b0;
        end else begin
            if (k_phase) begin
                cmd_v <= rd_take;
                if (rd_take) cmd_a <= addr;
            end
            if (launch) begin
                base <= cmd_a;
                run  <= run_launch();
            end else if (run.act) begin
                run <= run_step(run);
            end
            rvalid <= rd_fire;
            oe     <= rd_fire;
        end
    end

endmodule

// File: rtl/qb4_wr_ctrl.sv
module qb4_wr_ctrl
    import qb4_pkg::*;
#(
    parameter  int ADDR_W = 4,
    localparam int WA_W   = ADDR_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              k_phase,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              wr_take,
    output logic              wr_fire,
    output logic [WA_W-1:0]   wr_word_addr
);

    wcmd_e             stage;
    logic [ADDR_W-1:0] cmd_a;
    logic [ADDR_W-1:0] base;
    run_t              run;
    logic              launch;

    assign wr_take = k_phase && !wr_n && (stage == WC_IDLE);
    assign launch  = k_phase && (stage == WC_ARMED);
    assign wr_fire = launch || run.act;

    always_comb begin
        if (launch) wr_word_addr = {cmd_a, {IDX_W{1'b0}}};
        else        wr_word_addr = {base, run.idx};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= WC_IDLE;
            cmd_a <= '0;
            base  <= '0;
            run   <= '0;
        end else begin
            if (k_phase) begin
                stage <= wr_take ? WC_GET_ADDR : WC_IDLE;
            end else if (stage == WC_GET_ADDR) begin
                // write address rides the falling-edge beat
                cmd_a <= addr;
                stage <= WC_ARMED;
            end
            if (launch) begin
                base <= cmd_a;
                run  <= run_launch();
            end else if (run.act) begin
                run <= run_step(run);
            end
        end
    end

endmodule

// File: rtl/qb4_array.sv
module qb4_array
    import qb4_pkg::*;
#(
    parameter  int DATA_W = 18,
    parameter  int WA_W   = 6,
    localparam int LANES  = lanes_of(DATA_W),
    localparam int DEPTH  = 1 << WA_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic [WA_W-1:0]   waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  lane_en,
    input  logic              re,
    input  logic [WA_W-1:0]   raddr,
    output logic [DATA_W-1:0] rdata
);

    // one storage column per 9-bit lane
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rq;

        always_ff @(posedge clk) begin
            if (we && lane_en[g]) mem[waddr] <= wdata[g*LANE_W +: LANE_W];
            if (re)               rq         <= mem[raddr];
        end

        assign rdata[g*LANE_W +: LANE_W] = rq;
    end

endmodule

// File: rtl/qb4_sram.sv
module qb4_sram
    import qb4_pkg::*;
#(
    parameter  int ADDR_W = 4,
    parameter  int DATA_W = 18,
    localparam int LANES  = lanes_of(DATA_W),
    localparam int WA_W   = ADDR_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              k_phase,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [LANES-1:0]  bw_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              oe
);

    logic            rd_take;
    logic            rd_fire;
    logic [WA_W-1:0] rd_word_addr;
    logic            wr_take;
    logic            wr_fire;
    logic [WA_W-1:0] wr_word_addr;

    qb4_rd_ctrl #(.ADDR_W(ADDR_W)) u_rd (
        .clk          (clk),
        .rst          (rst),
        .k_phase      (k_phase),
        .rd_n         (rd_n),
        .addr         (addr),
        .rd_take      (rd_take),
        .rd_fire      (rd_fire),
        .rd_word_addr (rd_word_addr),
        .rvalid       (rvalid),
        .oe           (oe)
    );

    qb4_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .clk          (clk),
        .rst          (rst),
        .k_phase      (k_phase),
        .wr_n         (wr_n),
        .addr         (addr),
        .wr_take      (wr_take),
        .wr_fire      (wr_fire),
        .wr_word_addr (wr_word_addr)
    );

    qb4_array #(.DATA_W(DATA_W), .WA_W(WA_W)) u_mem (
        .clk     (clk),
        .we      (wr_fire),
        .waddr   (wr_word_addr),
        .wdata   (wdata),
        .lane_en (~bw_n),
        .re      (rd_fire),
        .raddr   (rd_word_addr),
        .rdata   (rdata)
    );

endmodule

// File: rtl/qb4_sram_chk.sv
module qb4_sram_chk #(
    parameter  int ADDR_W = 4,
    localparam int WA_W   = ADDR_W + 2
) (
    input logic            clk,
    input logic            rst,
    input logic            rd_take,
    input logic            wr_take,
    input logic            rd_fire,
    input logic            wr_fire,
    input logic [WA_W-1:0] rd_word_addr,
    input logic [WA_W-1:0] wr_word_addr,
    input logic            rvalid,
    input logic            oe
);

    logic [1:0] rd_run;
    logic [1:0] wr_run;

    always_ff @(posedge clk) begin
        if (rst || !rd_fire) rd_run <= '0;
        else                 rd_run <= rd_run + 2'd1;
        if (rst || !wr_fire) wr_run <= '0;
        else                 wr_run <= wr_run + 2'd1;
    end

    // R3: accepted read launches word 0 two beats on, strobe follows
    p_first_beat_r3: assert property (@(posedge clk) disable iff (rst)
        rd_take |-> ##2 (rd_fire && rd_word_addr[1:0] == 2'd0) ##1 rvalid);

    // R1: read words advance by one within a burst
    p_rd_order_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_fire && rd_word_addr[1:0] != 2'd0) |->
            ($past(rd_fire) && rd_word_addr == $past(rd_word_addr) + 1'b1));

    // R1: write words advance by one within a burst
    p_wr_order_r1: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && wr_word_addr[1:0] != 2'd0) |->
            ($past(wr_fire) && wr_word_addr == $past(wr_word_addr) + 1'b1));

    // R1: every read run ends on a multiple of four beats
    p_rd_len_r1: assert property (@(posedge clk) disable iff (rst)
        (!rd_fire && $past(rd_fire)) |-> rd_run == 2'd0);

    // R1: every write run ends on a multiple of four beats
    p_wr_len_r1: assert property (@(posedge clk) disable iff (rst)
        (!wr_fire && $past(wr_fire)) |-> wr_run == 2'd0);

    // R7: no read acceptance on the rising-edge beat after one
    p_rd_drop_r7: assert property (@(posedge clk) disable iff (rst)
        rd_take |-> ##2 !rd_take);

    // R7: no write acceptance on the rising-edge beat after one
    p_wr_drop_r7: assert property (@(posedge clk) disable iff (rst)
        wr_take |-> ##2 !wr_take);

    // R8: drivers off whenever no read beat is presented
    p_oe_off_r8: assert property (@(posedge clk) disable iff (rst)
        !rvalid |-> !oe);

    // R10: outputs quiet right after a reset beat
    p_rst_quiet_r10: assert property (@(posedge clk)
        $past(rst) |-> (!rvalid && !oe));

endmodule

bind qb4_sram qb4_sram_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .rd_take      (rd_take),
    .wr_take      (wr_take),
    .rd_fire      (rd_fire),
    .wr_fire      (wr_fire),
    .rd_word_addr (rd_word_addr),
    .wr_word_addr (wr_word_addr),
    .rvalid       (rvalid),
    .oe           (oe)
);

// File: tb/qb4_sram_tb.sv
module qb4_sram_tb_top;

    localparam int CLK_P = 10;
    localparam int AW    = 3;
    localparam int DW    = 18;
    localparam int LN    = 2;
    localparam int NW    = 4 << AW;
    localparam int NB    = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          k_phase;
    logic          rd_n;
    logic          wr_n;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [LN-1:0] bw_n;
    logic [DW-1:0] rdata;
    logic          rvalid;
    logic          oe;

    always #(CLK_P/2) clk = ~clk;

    qb4_sram #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .k_phase (k_phase),
        .rd_n    (rd_n),
        .wr_n    (wr_n),
        .addr    (addr),
        .wdata   (wdata),
        .bw_n    (bw_n),
        .rdata   (rdata),
        .rvalid  (rvalid),
        .oe      (oe)
    );

    int    n_run  = 0;
    int    n_fail = 0;
    int    bt     = 0;
    string sec    = "R10 reset";

    // reference contents and beat-indexed schedules
    logic [DW-1:0] ref_mem [NW];
    bit            e_val [8];
    int            e_addr [8];
    bit            w_val [8];
    int            w_addr [8];
    int            last_r = -100;
    int            last_w = -100;
    bit            w_need = 1'b0;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%0h exp=%0h beat=%0d", sec, what, act, exp, bt);
        end
    endtask

    // one beat: drive, predict, clock, compare
    task automatic step(input bit rd, input bit wr, input int a, input logic [DW-1:0] d,
                        input logic [LN-1:0] bw);
        bit            ev;
        logic [DW-1:0] ed;
        int            s;
        k_phase = (bt % 2 == 0);
        rd_n    = !rd;
        wr_n    = !wr;
        addr    = AW'(a);
        wdata   = d;
        bw_n    = bw;
        if (k_phase) begin
            if (rd && last_r != bt - 2) begin
                last_r = bt;
                for (int i = 0; i < 4; i++) begin
                    e_val[(bt + 2 + i) % 8]  = 1'b1;
                    e_addr[(bt + 2 + i) % 8] = (a % NB) * 4 + i;
                end
            end
            if (wr && last_w != bt - 2) begin
                last_w = bt;
                w_need = 1'b1;
            end
        end else if (w_need) begin
            w_need = 1'b0;
            for (int i = 0; i < 4; i++) begin
                w_val[(bt + 1 + i) % 8]  = 1'b1;
                w_addr[(bt + 1 + i) % 8] = (a % NB) * 4 + i;
            end
        end
        s  = bt % 8;
        ev = e_val[s];
        ed = ev ? ref_mem[e_addr[s]] : '0;
        e_val[s] = 1'b0;
        if (w_val[s]) begin
            for (int j = 0; j < LN; j++)
                if (!bw[j]) ref_mem[w_addr[s]][j*9 +: 9] = d[j*9 +: 9];
            w_val[s] = 1'b0;
        end
        @(posedge clk);
        #1;
        check("rvalid", 32'(rvalid), 32'(ev));
        check("oe", 32'(oe), 32'(ev));
        if (ev) check("rdata", 32'(rdata), 32'(ed));
        bt++;
    endtask

    function automatic logic [DW-1:0] rnd_d();
        return DW'($urandom);
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, int'($urandom % NB), rnd_d(), '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            e_val[i] = 1'b0;
            w_val[i] = 1'b0;
        end
        for (int i = 0; i < NW; i++) ref_mem[i] = '0;

        // R10: requests during reset are discarded, outputs low
        rst = 1'b1; rd_n = 1'b0; wr_n = 1'b0; addr = '0; wdata = '0; bw_n = '0;
        for (int i = 0; i < 6; i++) begin
            k_phase = (i % 2 == 0);
            @(posedge clk);
            #1;
            check("rvalid in reset", 32'(rvalid), 32'd0);
            check("oe in reset", 32'(oe), 32'd0);
        end
        rst = 1'b0;
        idle(6);

        // R4 R5 R1: seamless writes filling every burst, full lanes
        sec = "R4/R5/R1 fill";
        for (int b = 0; b < NB; b++) begin
            step(1'b0, 1'b1, int'($urandom % NB), rnd_d(), '0);
            step(1'b0, 1'b0, b, rnd_d(), '0);
            step(1'b0, 1'b0, int'($urandom % NB), rnd_d(), '0);
            step(1'b0, 1'b0, int'($urandom % NB), rnd_d(), '0);
        end
        idle(4);

        // R2 R3 R1: seamless reads of every burst, descending order
        sec = "R2/R3/R1 readback";
        for (int b = NB - 1; b >= 0; b--) begin
            step(1'b1, 1'b0, b, rnd_d(), '0);
            step(1'b0, 1'b0, int'($urandom % NB), rnd_d(), '0);
            step(1'b0, 1'b0, int'($urandom % NB), rnd_d(), '0);
            step(1'b0, 1'b0, int'($urandom % NB), rnd_d(), '0);
        end
        // R8: deselect after final word
        sec = "R8 deselect";
        idle(6);

        // R6: every lane-enable combination on every word offset
        sec = "R6 lanes";
        for (int b = 0; b < NB; b++) begin
            for (int r = 0; r < 4; r++) begin
                step(1'b0, 1'b1, 0, rnd_d(), LN'(r));
                step(1'b0, 1'b0, b, rnd_d(), LN'(r));
                step(1'b0, 1'b0, 0, rnd_d(), LN'(r + 1));
                step(1'b0, 1'b0, 0, rnd_d(), LN'(r + 2));
            end
        end
        idle(4);
        for (int b = 0; b < NB; b++) begin
            step(1'b1, 1'b0, b, rnd_d(), '0);
            idle(3);
        end
        idle(4);

        // R7: mid-burst requests of both kinds are dropped
        sec = "R7 mid-burst drop";
        for (int k = 0; k < 6; k++) begin
            step(1'b1, 1'b1, k % NB, rnd_d(), '0);
            step(1'b0, 1'b0, (k + 3) % NB, rnd_d(), '0);
            step(1'b1, 1'b1, (k + 5) % NB, rnd_d(), '0);
            step(1'b1, 1'b1, (k + 6) % NB, rnd_d(), '0);
        end
        idle(6);
        for (int b = 0; b < NB; b++) begin
            step(1'b1, 1'b0, b, rnd_d(), '0);
            idle(3);
        end
        idle(4);

        // R2 R4: requests on falling-edge beats have no effect
        sec = "R2/R4 falling-edge ignored";
        for (int k = 0; k < 8; k++) begin
            step(1'b0, 1'b0, k % NB, rnd_d(), '0);
            step(1'b1, 1'b1, k % NB, rnd_d(), '0);
        end
        idle(4);

        // R9: read and write to same burst on same beat return old words
        sec = "R9 no forwarding";
        for (int b = 0; b < NB; b++) begin
            step(1'b1, 1'b1, b, rnd_d(), '0);
            step(1'b0, 1'b0, b, rnd_d(), '0);
            step(1'b0, 1'b0, 0, rnd_d(), '0);
            step(1'b0, 1'b0, 0, rnd_d(), '0);
        end
        idle(6);
        // R9: read one slot behind a write to the same burst
        for (int b = 0; b < NB; b++) begin
            step(1'b0, 1'b1, 0, rnd_d(), '0);
            step(1'b0, 1'b0, b, rnd_d(), '0);
            step(1'b1, 1'b0, b, rnd_d(), '0);
            step(1'b0, 1'b0, 0, rnd_d(), '0);
            idle(4);
        end
        idle(4);

        // R9 R5 R6 R7: randomized mixed traffic
        sec = "R9/R5/R6/R7 random mix";
        for (int k = 0; k < 1600; k++) begin
            step(($urandom % 3) != 0, ($urandom % 3) != 0, int'($urandom % NB),
                 rnd_d(), LN'($urandom));
        end
        idle(8);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule